// File: doc/BRIEF.md
# Hardware Stop Mode Controller

This block keeps track of a processor core's power state and drives the clock controls that go with each state. There are four states: normal run, halt, software stop and hardware stop. An active-low external stop input forces hardware stop from any of the other three states. In hardware stop the block turns off the CPU and peripheral clock enables. It also raises a registered request that tells an external clock generator to stop. That request is held back for as long as the bus-lock input is high, because a slave on the locked bus may still need its clock.

On entry the block stores the state it left. When the stop input rises again, the block uses that stored state to return to halt if it came from halt, or to normal run otherwise. A synchronous reset ends any state and returns to normal run. A compile-time mask option makes the stop input ignored while the bus is locked. Entry is then deferred until the lock drops, provided the stop input is still low at that point.

Top module: `pwr_stop_ctrl`

## Requirements
- R1: While rst_n is sampled low at a rising clk edge, state_code becomes 00 after that edge, with cpu_clk_en=1, per_clk_en=0→1 (both enables 1) and clkgen_stop_req=0.
- R2: From run (00), a one-cycle halt_req pulse gives state 01 after the edge and a sstop_req pulse gives 10; when both are high together, software stop (10) wins.
- R3: The clock enables per state are: run cpu=1 per=1; halt cpu=0 per=1; software stop cpu=0 per=0; hardware stop (11) cpu=0 per=0.
- R4: stop_n passes through a two-flop synchronizer. A low level on stop_n driven before edge k moves the state from run, halt or software stop to 11 after edge k+2, and the state is unchanged after edge k+1.
- R5: clkgen_stop_req is a register. It is 1 after an edge exactly when the state after that edge is 11 and bus_lock was low at that edge. It is never 1 outside state 11.
- R6: With the mask option off, a stop entered while bus_lock is high still gives state 11 with both enables 0, but clkgen_stop_req stays 0 until one edge after bus_lock falls.
- R7: A low-to-high transition of the synchronized stop input ends hardware stop after edge k+2 (stop_n raised before edge k). The state goes to 01 if it was 01 before entry, and to 00 if it was 00 or 10 before entry.
- R8: In halt or software stop, a wake pulse returns the state to 00 after the edge only while the synchronized stop input is high. Otherwise the state does not go to run.
- R9: With MASK_ON_LOCK=1, a low stop input is ignored while bus_lock is high. If stop_n is still low, the state becomes 11 one edge after bus_lock falls, with clkgen_stop_req=1 at that same edge.
- R10: Reset asserted during hardware stop gives state 00 with both enables high and clkgen_stop_req low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; must meet setup/hold to clk |
| stop_n | input | 1 | Asynchronous active-low hardware stop request |
| bus_lock | input | 1 | High while a locked bus sequence is in progress |
| halt_req | input | 1 | One-cycle request to enter halt from run |
| sstop_req | input | 1 | One-cycle request to enter software stop from run |
| wake | input | 1 | Wake event; returns halt or software stop to run |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clkgen_stop_req | output | 1 | Registered request to stop the external clock generator |
| state_code | output | 2 | 00 run, 01 halt, 10 software stop, 11 hardware stop |

## Verification
A wrong stored entry state shows up only at exit: three edges after stop_n rises, state_code lands on 00 where 01 was expected, or the reverse. The bench therefore leaves hardware stop from every prior state. A broken lock qualifier shows on clkgen_stop_req on the first edge with bus_lock high in state 11. A wrong synchronizer depth moves the entry and exit edge by one cycle, and the bench samples the cycle before and the cycle of each transition to catch it. A masked instance runs beside the unmasked one on the same stimulus, so any deferral error appears as a one-edge mismatch when the lock drops.

// File: rtl/pstop_pkg.sv
// Shared state encoding for the hardware stop controller.
// Assumes a 2-bit code that is exported directly as state_code.
package pstop_pkg;
    typedef enum logic [1:0] {
        PS_RUN    = 2'b00,
        PS_HALT   = 2'b01,
        PS_SSTOP  = 2'b10,
        PS_HWSTOP = 2'b11
    } pstate_e;
endpackage

// File: rtl/pstop_sync.sv
// Multi-flop synchronizer with rising-edge detect for the stop input.
// Assumes the input is asynchronous; the chain resets to 1 (inactive stop).
module pstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b1;
        else        level_d <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/pstop_fsm.sv
// Power state machine: run, halt, software stop and hardware stop.
// Stores the state it left on hardware stop entry and uses it to pick the exit state.
// Assumes stop_lvl/stop_rise are already synchronized to clk.
module pstop_fsm
    import pstop_pkg::*;
#(
    parameter bit MASK_ON_LOCK = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stop_lvl,
    input  logic    stop_rise,
    input  logic    bus_lock,
    input  logic    halt_req,
    input  logic    sstop_req,
    input  logic    wake,
    output pstate_e state,
    output pstate_e nxt_state
);
    pstate_e prior;
    logic    enter_hw;

    // Stop is honoured unless the mask option is on and the bus is locked.
    assign enter_hw = !stop_lvl && !(MASK_ON_LOCK && bus_lock);

    // Next-state decision; hardware stop entry overrides every other request.
    always_comb begin
        nxt_state = state;
        case (state)
            PS_RUN: begin
                if (enter_hw)       nxt_state = PS_HWSTOP;
                else if (sstop_req) nxt_state = PS_SSTOP;
                else if (halt_req)  nxt_state = PS_HALT;
            end
            PS_HALT, PS_SSTOP: begin
                if (enter_hw)               nxt_state = PS_HWSTOP;
                else if (wake && stop_lvl)  nxt_state = PS_RUN;
            end
            PS_HWSTOP: begin
                if (stop_rise) nxt_state = (prior == PS_HALT) ? PS_HALT : PS_RUN;
            end
            default: nxt_state = PS_RUN;
        endcase
    end

    // Current state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt_state;
    end

    // Capture the state being left when hardware stop is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prior <= PS_RUN;
        else if (state != PS_HWSTOP && nxt_state == PS_HWSTOP)
            prior <= state;
    end
endmodule

// File: rtl/pstop_outs.sv
// Clock enable decode and registered clock-generator stop request.
// Assumes nxt_state is the value the state register takes at the next edge.
module pstop_outs
    import pstop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state,
    input  pstate_e nxt_state,
    input  logic    bus_lock,
    output logic    cpu_clk_en,
    output logic    per_clk_en,
    output logic    clkgen_stop_req
);
    // Enables follow the current state: CPU only in run, peripherals in run or halt.
    always_comb begin
        cpu_clk_en = (state == PS_RUN);
        per_clk_en = (state == PS_RUN) || (state == PS_HALT);
    end

    // Request the generator stop only in hardware stop and with the bus free.
    always_ff @(posedge clk) begin
        if (!rst_n) clkgen_stop_req <= 1'b0;
        else        clkgen_stop_req <= (nxt_state == PS_HWSTOP) && !bus_lock;
    end
endmodule

// File: rtl/pwr_stop_ctrl.sv
// Top of the hardware stop controller: synchronizer, state machine, output stage.
// Assumes rst_n is synchronous to clk; stop_n may be fully asynchronous.
module pwr_stop_ctrl
    import pstop_pkg::*;
#(
    parameter bit MASK_ON_LOCK = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_n,
    input  logic       bus_lock,
    input  logic       halt_req,
    input  logic       sstop_req,
    input  logic       wake,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       clkgen_stop_req,
    output logic [1:0] state_code
);
    logic    stop_lvl;
    logic    stop_rise;
    pstate_e state;
    pstate_e nxt_state;

    pstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stop_n),
        .level    (stop_lvl),
        .rise     (stop_rise)
    );

    pstop_fsm #(.MASK_ON_LOCK(MASK_ON_LOCK)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_lvl  (stop_lvl),
        .stop_rise (stop_rise),
        .bus_lock  (bus_lock),
        .halt_req  (halt_req),
        .sstop_req (sstop_req),
        .wake      (wake),
        .state     (state),
        .nxt_state (nxt_state)
    );

    pstop_outs u_outs (
        .clk             (clk),
        .rst_n           (rst_n),
        .state           (state),
        .nxt_state       (nxt_state),
        .bus_lock        (bus_lock),
        .cpu_clk_en      (cpu_clk_en),
        .per_clk_en      (per_clk_en),
        .clkgen_stop_req (clkgen_stop_req)
    );

    assign state_code = state;
endmodule

// File: rtl/pstop_chk.sv
// Port-level checker for pwr_stop_ctrl, attached by bind.
// Assumes the state encoding 00 run, 01 halt, 10 software stop, 11 hardware stop.
module pstop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_lock,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       clkgen_stop_req,
    input logic [1:0] state_code
);
    AST_HW_CLKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b11 |-> !cpu_clk_en && !per_clk_en); // R3
    AST_RUN_CLKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b00 |-> cpu_clk_en && per_clk_en); // R3
    AST_HALT_PER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b01 |-> !cpu_clk_en && per_clk_en); // R3
    AST_REQ_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
        clkgen_stop_req |-> state_code == 2'b11); // R5
    AST_LOCK_WITHHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |=> !clkgen_stop_req); // R6
    AST_SSTOP_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b10 |=> state_code != 2'b01); // R2
endmodule

bind pwr_stop_ctrl pstop_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_lock        (bus_lock),
    .cpu_clk_en      (cpu_clk_en),
    .per_clk_en      (per_clk_en),
    .clkgen_stop_req (clkgen_stop_req),
    .state_code      (state_code)
);

// File: tb/tb_pwr_stop_ctrl.sv
// Bench: sweeps prior state x bus lock on an unmasked and a masked instance.
module tb_pwr_stop_ctrl;
    logic clk = 1'b0;
    logic rst_n, stop_n, bus_lock, halt_req, sstop_req, wake;
    logic cpu0, per0, req0, cpu1, per1, req1;
    logic [1:0] st0, st1;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwr_stop_ctrl #(.MASK_ON_LOCK(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .bus_lock(bus_lock),
        .halt_req(halt_req), .sstop_req(sstop_req), .wake(wake),
        .cpu_clk_en(cpu0), .per_clk_en(per0), .clkgen_stop_req(req0), .state_code(st0));

    pwr_stop_ctrl #(.MASK_ON_LOCK(1'b1)) dut_msk (
        .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .bus_lock(bus_lock),
        .halt_req(halt_req), .sstop_req(sstop_req), .wake(wake),
        .cpu_clk_en(cpu1), .per_clk_en(per1), .clkgen_stop_req(req1), .state_code(st1));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, then sample mid-cycle.
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Drive a one-cycle pulse (inputs change away from the edge).
    task automatic pulse_halt();  halt_req = 1;  tick(1); halt_req = 0;  endtask
    task automatic pulse_sstop(); sstop_req = 1; tick(1); sstop_req = 0; endtask
    task automatic pulse_wake();  wake = 1;      tick(1); wake = 0;      endtask

    task automatic do_reset();
        rst_n = 0; stop_n = 1; bus_lock = 0; halt_req = 0; sstop_req = 0; wake = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    // Expected enables per state code.
    function automatic int exp_cpu(int s); return (s == 0) ? 1 : 0; endfunction
    function automatic int exp_per(int s); return (s <= 1) ? 1 : 0; endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "state", st0, 0);
        chk("R1", "cpu_en", cpu0, 1);
        chk("R1", "per_en", per0, 1);
        chk("R1", "req", req0, 0);

        // R2 priority: both requests together pick software stop.
        halt_req = 1; sstop_req = 1; tick(1); halt_req = 0; sstop_req = 0;
        chk("R2", "both req state", st0, 2);
        chk("R3", "sstop cpu", cpu0, 0);
        chk("R3", "sstop per", per0, 0);
        pulse_wake();
        chk("R8", "wake from sstop", st0, 0);

        // Sweep prior state (0 run, 1 halt, 2 sstop) x bus lock.
        for (int p = 0; p < 3; p++) begin
            for (int lk = 0; lk < 2; lk++) begin
                int ex;
                do_reset();
                if (p == 1) pulse_halt();
                if (p == 2) pulse_sstop();
                chk("R2", "prior state", st0, p);
                chk("R3", "prior cpu", cpu0, exp_cpu(p));
                chk("R3", "prior per", per0, exp_per(p));
                bus_lock = lk[0];
                stop_n = 0;
                tick(2);
                chk("R4", "not yet entered", st0, p);
                tick(1);
                chk("R4", "entered hw stop", st0, 3);
                chk("R3", "hw cpu", cpu0, 0);
                chk("R3", "hw per", per0, 0);
                chk(lk ? "R6" : "R5", "req on entry", req0, lk ? 0 : 1);
                chk("R9", "masked state", st1, lk ? p : 3);
                if (lk) begin
                    bus_lock = 0;
                    tick(1);
                    chk("R6", "req after unlock", req0, 1);
                    chk("R9", "deferred entry", st1, 3);
                    chk("R9", "deferred req", req1, 1);
                end
                stop_n = 1;
                tick(2);
                chk("R7", "still hw stop", st0, 3);
                tick(1);
                ex = (p == 1) ? 1 : 0;
                chk("R7", "exit state", st0, ex);
                chk("R7", "exit state masked", st1, ex);
                chk("R5", "req off after exit", req0, 0);
            end
        end

        // R8: masked instance in halt ignores wake while stop is low.
        do_reset();
        pulse_halt();
        bus_lock = 1; stop_n = 0;
        tick(3);
        chk("R9", "masked halt holds", st1, 1);
        pulse_wake();
        chk("R8", "wake blocked by low stop", st1, 1);
        bus_lock = 0;
        tick(1);
        chk("R9", "entry after unlock", st1, 3);
        stop_n = 1;
        tick(3);
        chk("R7", "masked back to halt", st1, 1);
        pulse_wake();
        chk("R8", "wake from halt", st1, 0);
        chk("R8", "wake from halt unmasked", st0, 0);

        // R10: reset during hardware stop.
        do_reset();
        stop_n = 0;
        tick(3);
        chk("R4", "entered before reset", st0, 3);
        rst_n = 0;
        tick(1);
        chk("R10", "reset state", st0, 0);
        chk("R10", "reset cpu", cpu0, 1);
        chk("R10", "reset per", per0, 1);
        chk("R10", "reset req", req0, 0);
        stop_n = 1;
        rst_n = 1;
        tick(4);
        chk("R10", "stays run", st0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule